// File: doc/BRIEF.md
# Operand Address Generator

This block turns the addressing fields of a 68000-style operand specifier into an operand location. A caller presents a 3-bit mode, a 3-bit register field, an access size and the current program counter. The block reads the base register through a register-file read port. It pulls the 16-bit extension words it needs from an instruction-word stream, which is zero, one or two words depending on the mode. It then reports one of three things: a memory address, a register-direct selection, or an immediate value. For the auto-increment and auto-decrement modes it also reports the new value of the address register.

The request side and the extension-word side are both valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a caller holds its request until it is taken. An extension word is consumed on an edge where `ext_valid` and `ext_ready` are both high. `ext_ready` is high only while the block still needs a word, so the word source may stall for any number of cycles. The result is shown for exactly one cycle, marked by `done`. The block performs no memory access and no decode of the instruction.

Top module: `ea_gen`

## Requirements
- R1: A request is accepted on an edge where `req_valid` and `req_ready` are high. `req_ready` is high only while idle. `done` is a one-cycle pulse, and the block is idle again in the cycle after it.
- R2: Mode 0 and mode 1 read no extension word and set `is_reg`. `addr` carries the register number: 0–7 for data register n (mode 0), 8–15 for address register n (mode 1).
- R3: Mode 2 returns the contents of address register n as `addr`, with no extension word and no register update.
- R4: Mode 3 returns address register n as `addr` and raises `wb_valid` with `done`, with `wb_sel` = n and `wb_data` = An + step. The size encoding is 0 byte, 1 word, 2 (or 3) long, and the step is 1, 2 and 4 respectively.
- R5: For a byte access through address register 7 in mode 3 or mode 4, the step is 2 instead of 1.
- R6: Mode 4 returns An − step as `addr` and writes that same value back through `wb_data`.
- R7: Mode 5 returns An plus the sign-extended extension word. Mode 7, register 2 returns the `req_pc` value captured at acceptance plus the sign-extended word.
- R8: Mode 6 (base An) and mode 7, register 3 (base captured PC) read one word. Its bits 15:12 select the index register: 0–7 data, 8–15 address. Bit 11 set uses the full 32-bit index, and bit 11 clear uses its low 16 bits sign-extended. Bits 7:0 are a signed displacement. The address is base + index + displacement.
- R9: Mode 7, register 0 sign-extends one word to 32 bits. Mode 7, register 1 reads two words and forms the address with the first word as the upper half.
- R10: Mode 7, register 4 sets `is_imm`. For a byte the value is the low 8 bits of one word, for a word it is one word zero-extended, and for a long it is two words with the first word upper.
- R11: Words are consumed only on `ext_valid && ext_ready`. `done` comes 2 cycles after the acceptance cycle, plus one cycle for each cycle spent in the word fetch.
- R12: Mode 7 with register 5, 6 or 7 reads no word and completes with `addr` = 0, `is_reg`, `is_imm` and `wb_valid` all low.
- R13: After reset, `req_ready` = 1, and `done`, `ext_ready` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 3 | Addressing mode field |
| req_reg | input | 3 | Register field |
| req_size | input | 2 | Access size: 0 byte, 1 word, 2/3 long |
| req_pc | input | 32 | PC value before any extension word |
| rf_sel | output | 4 | Register-file read select, 0–7 data, 8–15 address |
| rf_rdata | input | 32 | Register-file read data for `rf_sel`, same cycle |
| ext_valid | input | 1 | Extension word present |
| ext_ready | output | 1 | Block wants an extension word |
| ext_data | input | 16 | Extension word |
| done | output | 1 | Result valid for this cycle |
| addr | output | 32 | Address, immediate value or register number |
| is_reg | output | 1 | Operand is a register |
| is_imm | output | 1 | Operand is an immediate value in `addr` |
| wb_valid | output | 1 | Address register update request |
| wb_sel | output | 3 | Address register number to update |
| wb_data | output | 32 | New address register value |

## Verification
The assertions check several properties on every cycle. `done` never lasts longer than a cycle, and the block is ready right after it. A word request never overlaps an accepted request or a result. The two operand flags are exclusive, and a register result names one of the sixteen registers. A register update appears only with `done`, and differs from `addr` by zero or by a legal step. The bench scenarios are needed to show the rest: the actual address arithmetic, the sign extensions, the index size bit, the high-word-first order, the A7 byte step, the PC capture, and the exact latency under a stalled word stream.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EXT_W = 16;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG_ALT = 2'd3
  } ea_size_e;

  typedef enum logic [3:0] {
    K_DREG, K_AREG, K_IND, K_POSTINC, K_PREDEC, K_DISP, K_INDEX,
    K_ABSW, K_ABSL, K_PCDISP, K_PCINDEX, K_IMM, K_BAD
  } ea_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_FETCH, S_CALC, S_DONE
  } ea_state_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic [2:0]       regf,
  input  ea_size_e         size,
  output ea_kind_e         kind,
  output logic [1:0]       n_ext,
  output logic [SEL_W-1:0] base_sel
);
  always_comb begin
    base_sel = {(mode != 3'd0), regf};
    n_ext    = 2'd0;
    kind     = K_BAD;
    case (mode)
      3'd0: kind = K_DREG;
      3'd1: kind = K_AREG;
      3'd2: kind = K_IND;
      3'd3: kind = K_POSTINC;
      3'd4: kind = K_PREDEC;
      3'd5: begin kind = K_DISP;  n_ext = 2'd1; end
      3'd6: begin kind = K_INDEX; n_ext = 2'd1; end
      default: begin
        case (regf)
          3'd0: begin kind = K_ABSW;    n_ext = 2'd1; end
          3'd1: begin kind = K_ABSL;    n_ext = 2'd2; end
          3'd2: begin kind = K_PCDISP;  n_ext = 2'd1; end
          3'd3: begin kind = K_PCINDEX; n_ext = 2'd1; end
          3'd4: begin
            kind  = K_IMM;
            n_ext = (size == SZ_BYTE || size == SZ_WORD) ? 2'd1 : 2'd2;
          end
          default: begin kind = K_BAD; n_ext = 2'd0; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ea_step_calc.sv
module ea_step_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STACK_REG  = 7,
  parameter bit STACK_EVEN = 1'b1
) (
  input  ea_size_e          size,
  input  logic [2:0]        regf,
  output logic [ADDR_W-1:0] step
);
  logic [ADDR_W-1:0] byte_step;

  generate
    if (STACK_EVEN) begin : g_even_stack
      assign byte_step = (regf == 3'(STACK_REG)) ? ADDR_W'(2) : ADDR_W'(1);
    end else begin : g_plain_stack
      logic unused_regf;
      assign unused_regf = ^regf;
      assign byte_step = ADDR_W'(1);
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: step = byte_step;
      SZ_WORD: step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ea_kind_e          kind,
  input  ea_size_e          size,
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] step,
  input  logic [EXT_W-1:0]  w0,
  input  logic [EXT_W-1:0]  w1,
  input  logic [ADDR_W-1:0] idx_raw,
  output logic [ADDR_W-1:0] addr,
  output logic              is_reg,
  output logic              is_imm,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_data
);
  logic [ADDR_W-1:0] sx_w0, disp8, index, pair;

  assign sx_w0 = {{(ADDR_W-EXT_W){w0[EXT_W-1]}}, w0};
  assign disp8 = {{(ADDR_W-8){w0[7]}}, w0[7:0]};
  assign index = w0[11] ? idx_raw
                        : {{(ADDR_W-EXT_W){idx_raw[EXT_W-1]}}, idx_raw[EXT_W-1:0]};
  assign pair  = ADDR_W'({w0, w1});

  always_comb begin
    addr    = '0;
    is_reg  = 1'b0;
    is_imm  = 1'b0;
    wb_en   = 1'b0;
    wb_data = '0;
    case (kind)
      K_DREG, K_AREG: begin
        is_reg = 1'b1;
        addr   = ADDR_W'(base_sel);
      end
      K_IND:     addr = base;
      K_POSTINC: begin
        addr    = base;
        wb_en   = 1'b1;
        wb_data = base + step;
      end
      K_PREDEC: begin
        addr    = base - step;
        wb_en   = 1'b1;
        wb_data = base - step;
      end
      K_DISP:    addr = base + sx_w0;
      K_INDEX:   addr = base + index + disp8;
      K_ABSW:    addr = sx_w0;
      K_ABSL:    addr = pair;
      K_PCDISP:  addr = pc + sx_w0;
      K_PCINDEX: addr = pc + index + disp8;
      K_IMM: begin
        is_imm = 1'b1;
        case (size)
          SZ_BYTE: addr = ADDR_W'(w0[7:0]);
          SZ_WORD: addr = ADDR_W'(w0);
          default: addr = pair;
        endcase
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_mode,
  input  logic [2:0]        req_reg,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_pc,
  output logic [3:0]        rf_sel,
  input  logic [ADDR_W-1:0] rf_rdata,
  input  logic              ext_valid,
  output logic              ext_ready,
  input  logic [15:0]       ext_data,
  output logic              done,
  output logic [ADDR_W-1:0] addr,
  output logic              is_reg,
  output logic              is_imm,
  output logic              wb_valid,
  output logic [2:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_data
);
  ea_state_e         state;
  ea_kind_e          kind_q, dec_kind;
  ea_size_e          size_q;
  logic [1:0]        need_q, dec_need;
  logic              cnt_q;
  logic [SEL_W-1:0]  sel_q, dec_sel;
  logic [ADDR_W-1:0] base_q, pc_q, step;
  logic [EXT_W-1:0]  w0_q, w1_q;

  logic [ADDR_W-1:0] c_addr, c_wb_data;
  logic              c_is_reg, c_is_imm, c_wb_en;

  logic [ADDR_W-1:0] addr_q, wb_data_q;
  logic              is_reg_q, is_imm_q, wb_q;

  ea_mode_decode u_dec (
    .mode     (req_mode),
    .regf     (req_reg),
    .size     (ea_size_e'(req_size)),
    .kind     (dec_kind),
    .n_ext    (dec_need),
    .base_sel (dec_sel)
  );

  ea_step_calc #(.ADDR_W(ADDR_W)) u_step (
    .size (size_q),
    .regf (sel_q[2:0]),
    .step (step)
  );

  ea_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .kind     (kind_q),
    .size     (size_q),
    .base_sel (sel_q),
    .base     (base_q),
    .pc       (pc_q),
    .step     (step),
    .w0       (w0_q),
    .w1       (w1_q),
    .idx_raw  (rf_rdata),
    .addr     (c_addr),
    .is_reg   (c_is_reg),
    .is_imm   (c_is_imm),
    .wb_en    (c_wb_en),
    .wb_data  (c_wb_data)
  );

  // The index register is read in the calc cycle; the base at acceptance.
  assign rf_sel    = (state == S_CALC) ? w0_q[15:12] : dec_sel;
  assign req_ready = (state == S_IDLE);
  assign ext_ready = (state == S_FETCH);
  assign done      = (state == S_DONE);
  assign addr      = addr_q;
  assign is_reg    = is_reg_q;
  assign is_imm    = is_imm_q;
  assign wb_valid  = done && wb_q;
  assign wb_sel    = sel_q[2:0];
  assign wb_data   = wb_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind_q    <= K_BAD;
      size_q    <= SZ_BYTE;
      need_q    <= 2'd0;
      cnt_q     <= 1'b0;
      sel_q     <= '0;
      base_q    <= '0;
      pc_q      <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      addr_q    <= '0;
      wb_data_q <= '0;
      is_reg_q  <= 1'b0;
      is_imm_q  <= 1'b0;
      wb_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            kind_q <= dec_kind;
            size_q <= ea_size_e'(req_size);
            need_q <= dec_need;
            sel_q  <= dec_sel;
            base_q <= rf_rdata;
            pc_q   <= req_pc;
            cnt_q  <= 1'b0;
            state  <= (dec_need == 2'd0) ? S_CALC : S_FETCH;
          end
        end
        S_FETCH: begin
          if (ext_valid) begin
            if (!cnt_q) w0_q <= ext_data;
            else        w1_q <= ext_data;
            if ({1'b0, cnt_q} + 2'd1 == need_q) state <= S_CALC;
            else                                cnt_q <= 1'b1;
          end
        end
        S_CALC: begin
          addr_q    <= c_addr;
          is_reg_q  <= c_is_reg;
          is_imm_q  <= c_is_imm;
          wb_q      <= c_wb_en;
          wb_data_q <= c_wb_data;
          state     <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              ext_ready,
  input logic              done,
  input logic [ADDR_W-1:0] addr,
  input logic              is_reg,
  input logic              is_imm,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_data
);
  logic [ADDR_W-1:0] gap;
  assign gap = wb_data - addr;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R1
  AST_FETCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> (!req_ready && !done)); // R11
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(is_reg && is_imm)); // R2
  AST_REG_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_reg) |-> (addr < ADDR_W'(16))); // R2
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done); // R4
  AST_WB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (gap == '0 || gap == ADDR_W'(1) || gap == ADDR_W'(2) || gap == ADDR_W'(4))); // R6
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .ext_ready (ext_ready),
  .done      (done),
  .addr      (addr),
  .is_reg    (is_reg),
  .is_imm    (is_imm),
  .wb_valid  (wb_valid),
  .wb_data   (wb_data)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [2:0]  req_reg = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_pc = '0;
  logic [3:0]  rf_sel;
  logic [31:0] rf_rdata;
  logic        ext_valid = 1'b0;
  logic        ext_ready;
  logic [15:0] ext_data = '0;
  logic        done;
  logic [31:0] addr;
  logic        is_reg, is_imm, wb_valid;
  logic [2:0]  wb_sel;
  logic [31:0] wb_data;

  logic [31:0] rf [16];
  assign rf_rdata = rf[rf_sel];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_reg(req_reg), .req_size(req_size), .req_pc(req_pc),
    .rf_sel(rf_sel), .rf_rdata(rf_rdata), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .ext_data(ext_data), .done(done), .addr(addr), .is_reg(is_reg), .is_imm(is_imm),
    .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint s16(input longint x);
    return ((x & 'h8000) != 0) ? (x & 'hFFFF) - 65536 : (x & 'hFFFF);
  endfunction

  function automatic longint ix(input longint w);
    longint r = rf[(w >> 12) & 15];
    return ((w & 'h800) != 0) ? r : s16(r);
  endfunction

  // Behavioural reference for one request.
  task automatic model(input int mode, input int rg, input int size, input longint pc,
                       input longint w0, input longint w1,
                       output longint ea, output bit ereg, output bit eimm,
                       output bit ewb, output longint ewbd, output int nw);
    longint step, an;
    step = (size == 0) ? ((rg == 7) ? 2 : 1) : (size == 1) ? 2 : 4;
    an   = rf[8 + rg];
    ea = 0; ereg = 0; eimm = 0; ewb = 0; ewbd = 0; nw = 0;
    case (mode)
      0: begin ereg = 1; ea = rg; end
      1: begin ereg = 1; ea = 8 + rg; end
      2: ea = an;
      3: begin ea = an; ewb = 1; ewbd = an + step; end
      4: begin ea = an - step; ewb = 1; ewbd = an - step; end
      5: begin ea = an + s16(w0); nw = 1; end
      6: begin ea = an + ix(w0) + (((w0 & 'hFF) ^ 'h80) - 'h80); nw = 1; end
      default: case (rg)
        0: begin ea = s16(w0); nw = 1; end
        1: begin ea = (w0 << 16) | w1; nw = 2; end
        2: begin ea = pc + s16(w0); nw = 1; end
        3: begin ea = pc + ix(w0) + (((w0 & 'hFF) ^ 'h80) - 'h80); nw = 1; end
        4: begin
          eimm = 1;
          if (size == 0)      begin ea = w0 & 'hFF; nw = 1; end
          else if (size == 1) begin ea = w0; nw = 1; end
          else                begin ea = (w0 << 16) | w1; nw = 2; end
        end
        default: ;
      endcase
    endcase
    ea   = ea & 'hFFFF_FFFF;
    ewbd = ewbd & 'hFFFF_FFFF;
  endtask

  task automatic run(input string req, input int mode, input int rg, input int size,
                     input longint pc, input longint w0, input longint w1, input bit stall);
    longint ea, ewbd;
    bit ereg, eimm, ewb, fire;
    int nw, wi, cyc;
    longint words [2];
    words[0] = w0; words[1] = w1;
    model(mode, rg, size, pc, w0, w1, ea, ereg, eimm, ewb, ewbd, nw);
    @(negedge clk);
    req_mode = 3'(mode); req_reg = 3'(rg); req_size = 2'(size); req_pc = 32'(pc);
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1", {req, " ready idle"}, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    wi = 0; cyc = 1; fire = 1'b0;
    forever begin
      if (fire) wi++;
      ext_valid = (wi < nw) && (!stall || (cyc % 2 == 0));
      ext_data  = (wi < 2) ? 16'(words[wi]) : 16'h0;
      #1;
      fire = ext_valid && ext_ready;
      if (done) break;
      if (wb_valid) chk(1'b0, "R4", {req, " wb without done"}, wb_valid, 0);
      if (req_ready) chk(1'b0, "R1", {req, " ready while busy"}, req_ready, 0);
      if (cyc > 40) begin chk(1'b0, "R11", {req, " no done"}, cyc, 0); break; end
      @(negedge clk);
      cyc++;
    end
    ext_valid = 1'b0;
    chk(cyc == 2 + nw * (stall ? 2 : 1), "R11", {req, " latency"}, cyc, 2 + nw * (stall ? 2 : 1));
    chk(wi == nw, "R11", {req, " words used"}, wi, nw);
    chk(addr == 32'(ea), req, {req, " addr"}, addr, ea);
    chk(is_reg == ereg && is_imm == eimm, req, {req, " flags"}, {is_reg, is_imm}, {ereg, eimm});
    chk(wb_valid == ewb, req, {req, " wb_valid"}, wb_valid, ewb);
    if (ewb) begin
      chk(wb_data == 32'(ewbd), req, {req, " wb_data"}, wb_data, ewbd);
      chk(wb_sel == 3'(rg), req, {req, " wb_sel"}, wb_sel, rg);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0100;
    rf[3]  = 32'h0001_8004;
    rf[10] = 32'h0000_2000;
    rf[15] = 32'h0000_8000;
    rf[12] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(req_ready == 1 && done == 0 && ext_ready == 0 && wb_valid == 0, "R13", "reset outputs",
        {req_ready, done, ext_ready, wb_valid}, 4'b1000);
    rst_n = 1'b1;
    run("R2",  0, 3, 2, 0, 0, 0, 0);
    run("R2",  1, 5, 1, 0, 0, 0, 0);
    run("R3",  2, 2, 2, 0, 0, 0, 0);
    run("R4",  3, 1, 0, 0, 0, 0, 0);
    run("R4",  3, 1, 1, 0, 0, 0, 0);
    run("R4",  3, 2, 2, 0, 0, 0, 0);
    run("R5",  3, 7, 0, 0, 0, 0, 0);
    run("R5",  4, 7, 0, 0, 0, 0, 0);
    run("R6",  4, 2, 2, 0, 0, 0, 0);
    run("R6",  4, 1, 0, 0, 0, 0, 0);
    run("R6",  4, 4, 3, 0, 0, 0, 0);
    run("R7",  5, 2, 1, 0, 'hFFF0, 0, 1);
    run("R7",  5, 4, 1, 0, 'h0100, 0, 0);
    run("R7",  7, 2, 1, 'h0000_4000, 'h8002, 0, 0);
    run("R8",  6, 2, 1, 0, 'h30FE, 0, 0);
    run("R8",  6, 2, 1, 0, 'h3805, 0, 1);
    run("R8",  6, 2, 1, 0, 'hC880, 0, 0);
    run("R8",  7, 3, 1, 'h0000_1000, 'hA07F, 0, 1);
    run("R9",  7, 0, 1, 0, 'h8000, 0, 0);
    run("R9",  7, 1, 2, 0, 'h1234, 'h5678, 1);
    run("R10", 7, 4, 0, 0, 'hABCD, 0, 0);
    run("R10", 7, 4, 1, 0, 'hABCD, 0, 0);
    run("R10", 7, 4, 2, 0, 'hDEAD, 'hBEEF, 1);
    run("R12", 7, 5, 2, 0, 0, 0, 0);
    run("R12", 7, 7, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(req_ready == 1 && done == 0, "R1", "idle after last", {req_ready, done}, 2'b10);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule